// File: doc/BRIEF.md
# Pipelined Linear Track Fitter

This block turns the eight full-resolution cluster coordinates of one candidate track into five track parameters and a fit-quality figure. Each parameter is a fixed-point dot product of the coordinate vector with a stored coefficient row, plus a stored offset. The quality figure is built from three more rows of the same form. Each of these rows gives a residual, and the quality value is the sum of the three residuals squared. A programmable cut on that sum yields a pass flag.

The datapath is fully pipelined. A new coordinate set can enter on every clock, and results leave a fixed number of cycles later together with a delayed copy of the input valid flag. Coefficients, offsets and the cut are written one word at a time through a simple write port. The write port is normally used while no fits are in flight.

Top module: `track_fit_pipe`

## Requirements
- R1: While rst_ni is low and right after it rises, out_valid_o and pass_o are 0. Reset clears every coefficient and offset to 0, so a fit with reset constants gives all parameters 0, chi2_o 0 and pass_o 1. The cut resets to 40.
- R2: A write with cfg_we_i high stores cfg_data_i at cfg_addr_i on the rising edge. When bit 7 is 1, the 16-bit unsigned cut is written. When bit 7 is 0, bits 6:4 select the row and bits 3:0 select the column. Rows 0..4 are the parameters (q/pT, azimuth, pseudorapidity, transverse impact, longitudinal position), and rows 5..7 are the residuals. Columns 0..7 are the coefficients for coordinates 0..7, and column 8 is the row offset.
- R3: Each row computes acc = sum(c_j*x_j) + offset*256 + 128 in 40-bit signed arithmetic. All values are two's-complement 16-bit. The row result is floor(acc/256), which rounds half up.
- R4: A row result above 32767 is output as 32767, and one below -32768 as -32768. Parameters appear on param_o[k] for row k.
- R5: chi2_o is the sum of the squares of the three residual rows (each already clamped by R4). A sum above 2^24-1 is output as 16777215.
- R6: When out_valid_o is 1, pass_o is 1 exactly when the unclamped sum of squares is at most the cut. When out_valid_o is 0, pass_o is 0.
- R7: Coordinates sampled with in_valid_i at rising edge n produce outputs after rising edge n+5. out_valid_o follows in_valid_i with that same delay.
- R8: Fits on consecutive cycles are all produced, one per cycle, with no stall and no interference between them.
- R9: A write with bit 7 at 0 and a column of 9..15 changes no stored constant and leaves every later result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Coordinate set present this cycle |
| coord_i | input | 8x16 | Signed cluster coordinates, element j is coordinate j |
| cfg_we_i | input | 1 | Constant write strobe |
| cfg_addr_i | input | 8 | Constant address (cut, row, column) |
| cfg_data_i | input | 16 | Constant write data |
| out_valid_o | output | 1 | Results present |
| param_o | output | 5x16 | Signed track parameters, element k is row k |
| chi2_o | output | 24 | Clamped sum of squared residuals |
| pass_o | output | 1 | Fit passes the cut |

## Verification
The bench aims at the cut boundary, where the sum of squares is exactly 40 and then 41. An off-by-one comparator would flip pass_o on exactly one of those two. It drives all-maximum and all-minimum coordinates against maximum coefficients, and drives residual offsets large enough to overflow the 24-bit sum. A design that wrapped instead of clamping would return small or wrong-signed values there. It also streams fits back to back and with gaps, where a misaligned valid or parameter delay would pair results with the wrong input. Finally, it writes to unused columns, which a loose address decode would let corrupt a live coefficient.

// File: rtl/track_fit_pkg.sv
package track_fit_pkg;
  localparam int NUM_COORD = 8;
  localparam int COORD_W   = 16;
  localparam int COEF_W    = 16;
  localparam int ACC_W     = 40;
  localparam int FRAC_W    = 8;
  localparam int NUM_PAR   = 5;
  localparam int NUM_RES   = 3;
  localparam int NUM_ROW   = NUM_PAR + NUM_RES;
  localparam int RES_W     = 16;
  localparam int CHI_W     = 24;
  localparam int THR_W     = 16;
  localparam int THR_RST   = 40;
  localparam int ROW_AW    = $clog2(NUM_ROW);
  localparam int COL_AW    = 4;
  localparam int CFG_AW    = 1 + ROW_AW + COL_AW;
  localparam int LAT       = 6;

  typedef logic [NUM_COORD-1:0][COORD_W-1:0] coord_vec_t;
  typedef logic [NUM_COORD-1:0][COEF_W-1:0]  coef_row_t;
endpackage

// File: rtl/tf_coef_bank.sv
module tf_coef_bank import track_fit_pkg::*; (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [CFG_AW-1:0]                addr_i,
  input  logic [COEF_W-1:0]                data_i,
  output coef_row_t [NUM_ROW-1:0]          coef_o,
  output logic [NUM_ROW-1:0][COEF_W-1:0]   offs_o,
  output logic [THR_W-1:0]                 thr_o
);
  logic              sel_thr;
  logic [ROW_AW-1:0] row;
  logic [COL_AW-1:0] col;

  assign sel_thr = addr_i[CFG_AW-1];
  assign row     = addr_i[COL_AW +: ROW_AW];
  assign col     = addr_i[COL_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_o <= '0;
      offs_o <= '0;
      thr_o  <= THR_W'(THR_RST);
    end else if (we_i) begin
      if (sel_thr) begin
        thr_o <= THR_W'(data_i);
      end else begin
        for (int r = 0; r < NUM_ROW; r++) begin
          if (row == ROW_AW'(r)) begin
            for (int c = 0; c < NUM_COORD; c++)
              if (col == COL_AW'(c)) coef_o[r][c] <= data_i;
            if (col == COL_AW'(NUM_COORD)) offs_o[r] <= data_i;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tf_dot_row.sv
module tf_dot_row import track_fit_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  coord_vec_t        coord_i,
  input  coef_row_t         coef_i,
  input  logic [COEF_W-1:0] offs_i,
  output logic [RES_W-1:0]  res_o
);
  localparam int NP2 = NUM_COORD / 2;
  localparam int NP4 = NUM_COORD / 4;
  localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] RES_MAX = {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] RES_MIN = {{(ACC_W-RES_W+1){1'b1}}, {(RES_W-1){1'b0}}};

  logic signed [ACC_W-1:0] prod_d [NUM_COORD];
  logic signed [ACC_W-1:0] prod_q [NUM_COORD];
  logic signed [ACC_W-1:0] bias_q;
  logic signed [ACC_W-1:0] s2_q [NP2];
  logic signed [ACC_W-1:0] s4_q [NP4];
  logic signed [ACC_W-1:0] total, scaled;

  for (genvar j = 0; j < NUM_COORD; j++) begin : g_mul
    assign prod_d[j] = ACC_W'($signed(coef_i[j])) * ACC_W'($signed(coord_i[j]));
  end

  // S1: products and offset term; S2/S3: adder tree
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NUM_COORD; j++) prod_q[j] <= '0;
      for (int k = 0; k < NP2; k++) s2_q[k] <= '0;
      for (int k = 0; k < NP4; k++) s4_q[k] <= '0;
      bias_q <= '0;
    end else begin
      for (int j = 0; j < NUM_COORD; j++) prod_q[j] <= prod_d[j];
      bias_q <= (ACC_W'($signed(offs_i)) <<< FRAC_W) + HALF;
      for (int k = 0; k < NP2; k++)
        s2_q[k] <= prod_q[2*k] + prod_q[2*k+1] + ((k == NP2-1) ? bias_q : '0);
      for (int k = 0; k < NP4; k++)
        s4_q[k] <= s2_q[2*k] + s2_q[2*k+1];
    end
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < NP4; k++) total = total + s4_q[k];
    scaled = total >>> FRAC_W;
  end

  // S4: clamp to result width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 res_o <= '0;
    else if (scaled > RES_MAX)   res_o <= RES_MAX[RES_W-1:0];
    else if (scaled < RES_MIN)   res_o <= RES_MIN[RES_W-1:0];
    else                         res_o <= scaled[RES_W-1:0];
  end
endmodule

// File: rtl/tf_chi2.sv
module tf_chi2 import track_fit_pkg::*; (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic [NUM_RES-1:0][RES_W-1:0]   res_i,
  input  logic [THR_W-1:0]                thr_i,
  output logic [CHI_W-1:0]                chi2_o,
  output logic                            pass_o
);
  localparam int SQ_W  = 2 * RES_W;
  localparam int SUM_W = SQ_W + $clog2(NUM_RES + 1);
  localparam logic [SUM_W-1:0] CHI_MAX = SUM_W'({CHI_W{1'b1}});

  logic signed [SQ_W-1:0] sq_d [NUM_RES];
  logic [SQ_W-1:0]        sq_q [NUM_RES];
  logic                   vld_q;
  logic [SUM_W-1:0]       sum;

  for (genvar k = 0; k < NUM_RES; k++) begin : g_sq
    assign sq_d[k] = SQ_W'($signed(res_i[k])) * SQ_W'($signed(res_i[k]));
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < NUM_RES; k++) sum = sum + SUM_W'(sq_q[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_RES; k++) sq_q[k] <= '0;
      vld_q  <= 1'b0;
      chi2_o <= '0;
      pass_o <= 1'b0;
    end else begin
      for (int k = 0; k < NUM_RES; k++) sq_q[k] <= sq_d[k];
      vld_q  <= valid_i;
      chi2_o <= (sum > CHI_MAX) ? CHI_MAX[CHI_W-1:0] : sum[CHI_W-1:0];
      pass_o <= vld_q && (sum <= SUM_W'(thr_i));
    end
  end
endmodule

// File: rtl/track_fit_pipe.sv
module track_fit_pipe import track_fit_pkg::*; (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               in_valid_i,
  input  logic [NUM_COORD-1:0][COORD_W-1:0]  coord_i,
  input  logic                               cfg_we_i,
  input  logic [CFG_AW-1:0]                  cfg_addr_i,
  input  logic [COEF_W-1:0]                  cfg_data_i,
  output logic                               out_valid_o,
  output logic [NUM_PAR-1:0][RES_W-1:0]      param_o,
  output logic [CHI_W-1:0]                   chi2_o,
  output logic                               pass_o
);
  localparam int ROW_DONE = LAT - 3;  // valid tap aligned with row results

  coef_row_t [NUM_ROW-1:0]             coef;
  logic [NUM_ROW-1:0][COEF_W-1:0]      offs;
  logic [THR_W-1:0]                    thr_q;
  logic [NUM_ROW-1:0][RES_W-1:0]       row_res;
  logic [NUM_PAR-1:0][RES_W-1:0]       par_q;
  logic [LAT-1:0]                      vld_q;

  tf_coef_bank i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i),
    .coef_o (coef),
    .offs_o (offs),
    .thr_o  (thr_q)
  );

  for (genvar r = 0; r < NUM_ROW; r++) begin : g_row
    tf_dot_row i_row (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .coord_i (coord_i),
      .coef_i  (coef[r]),
      .offs_i  (offs[r]),
      .res_o   (row_res[r])
    );
  end

  tf_chi2 i_chi2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (vld_q[ROW_DONE]),
    .res_i   (row_res[NUM_ROW-1:NUM_PAR]),
    .thr_i   (thr_q),
    .chi2_o  (chi2_o),
    .pass_o  (pass_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      par_q   <= '0;
      param_o <= '0;
    end else begin
      vld_q   <= {vld_q[LAT-2:0], in_valid_i};
      par_q   <= row_res[NUM_PAR-1:0];
      param_o <= par_q;
    end
  end

  assign out_valid_o = vld_q[LAT-1];
endmodule

// File: rtl/tf_fit_checker.sv
module tf_fit_checker import track_fit_pkg::*; (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               out_valid_o,
  input logic               pass_o,
  input logic [CHI_W-1:0]   chi2_o,
  input logic [THR_W-1:0]   thr_q,
  input logic               cfg_we_i,
  input logic [CFG_AW-1:0]  cfg_addr_i,
  input logic [COEF_W-1:0]  cfg_data_i
);
  logic [3:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_q < 4'(LAT))   cnt_q <= cnt_q + 4'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!out_valid_o && !pass_o);
  end

  assert_valid_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= 4'(LAT)) |-> (out_valid_o == $past(in_valid_i, LAT)));

  assert_pass_cut_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != 0 && out_valid_o && $stable(thr_q)) |-> (pass_o == (chi2_o <= CHI_W'(thr_q))));

  assert_pass_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !pass_o);

  assert_thr_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i[CFG_AW-1]) |=> (thr_q == $past(cfg_data_i)));
endmodule

bind track_fit_pipe tf_fit_checker i_fit_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .pass_o      (pass_o),
  .chi2_o      (chi2_o),
  .thr_q       (thr_q),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_data_i  (cfg_data_i)
);

// File: tb/test_track_fit_pipe.sv
`timescale 1ns/1ps
module test_track_fit_pipe;
  localparam longint CHI_MAX = 64'd16777215;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0][15:0] coord = '0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic out_valid;
  logic [4:0][15:0] param;
  logic [23:0] chi2;
  logic pass;

  always #5 clk = ~clk;

  track_fit_pipe i_track_fit_pipe (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .coord_i(coord),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .out_valid_o(out_valid), .param_o(param), .chi2_o(chi2), .pass_o(pass)
  );

  int     checks = 0, fails = 0, cyc = 0;
  string  phase = "";
  int     m_cf [8][8];
  int     m_of [8];
  longint m_thr = 40;

  logic   rv [8];
  int     rp [8][5];
  longint rc [8];
  logic   rpass [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, phase, what, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint ref_row(input int r, input logic [7:0][15:0] x);
    longint acc = 0;
    for (int j = 0; j < 8; j++) acc += longint'(m_cf[r][j]) * longint'($signed(x[j]));
    acc += longint'(m_of[r]) * 256 + 128;
    return sat16(acc >>> 8);
  endfunction

  task automatic check_out();
    int i = (cyc + 2) & 7;
    logic ev = (cyc >= 6) ? rv[i] : 1'b0;
    chk(out_valid === ev, "R7", "out_valid", longint'(out_valid), longint'(ev));
    if (!ev) begin
      chk(pass === 1'b0, "R6", "pass while idle", longint'(pass), 0);
    end else begin
      for (int k = 0; k < 5; k++) begin
        longint a = longint'($signed(param[k]));
        chk(a == rp[i][k], (rp[i][k] == 32767 || rp[i][k] == -32768) ? "R4" : "R3",
            $sformatf("param[%0d]", k), a, rp[i][k]);
      end
      chk(longint'(chi2) == rc[i], "R5", "chi2", longint'(chi2), rc[i]);
      chk(pass === rpass[i], "R6", "pass", longint'(pass), longint'(rpass[i]));
    end
  endtask

  task automatic step(input logic v, input logic [7:0][15:0] x,
                      input logic we, input logic [7:0] a, input logic [15:0] d);
    int i = cyc & 7;
    longint s = 0;
    @(negedge clk);
    check_out();
    in_valid = v; coord = x; cfg_we = we; cfg_addr = a; cfg_data = d;
    rv[i] = v;
    for (int k = 0; k < 5; k++) rp[i][k] = int'(ref_row(k, x));
    for (int k = 5; k < 8; k++) begin
      longint r = ref_row(k, x);
      s += r * r;
    end
    rc[i] = (s > CHI_MAX) ? CHI_MAX : s;
    rpass[i] = v && (s <= m_thr);
    if (we) begin
      if (a[7]) m_thr = longint'(d);
      else if (a[3:0] < 8) m_cf[a[6:4]][a[3:0]] = int'($signed(d));
      else if (a[3:0] == 8) m_of[a[6:4]] = int'($signed(d));
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int t = 0; t < n; t++) step(1'b0, '0, 1'b0, '0, '0);
  endtask

  task automatic wr(input logic [7:0] a, input int d);
    step(1'b0, '0, 1'b1, a, 16'(d));
  endtask

  task automatic fit(input logic [7:0][15:0] x);
    step(1'b1, x, 1'b0, '0, '0);
  endtask

  function automatic logic [7:0][15:0] rnd_coord(input int span);
    logic [7:0][15:0] x;
    for (int j = 0; j < 8; j++) x[j] = 16'($urandom_range(0, 2*span) - span);
    return x;
  endfunction

  task automatic load_random(input int pspan, input int rspan);
    for (int r = 0; r < 8; r++) begin
      int sp = (r < 5) ? pspan : rspan;
      for (int c = 0; c < 8; c++) wr(8'((r << 4) | c), $urandom_range(0, 2*sp) - sp);
      wr(8'((r << 4) | 8), $urandom_range(0, 128) - 64);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    report();
    $finish;
  end

  initial begin
    logic [7:0][15:0] x;
    void'($urandom(32'h5eed_0042));
    for (int r = 0; r < 8; r++) begin
      m_of[r] = 0;
      for (int c = 0; c < 8; c++) m_cf[r][c] = 0;
    end
    for (int i = 0; i < 8; i++) rv[i] = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && pass === 1'b0, "R1", "valid/pass in reset",
        longint'({out_valid, pass}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && pass === 1'b0, "R1", "valid/pass after reset",
        longint'({out_valid, pass}), 0);

    phase = "R1 reset constants";
    for (int t = 0; t < 3; t++) fit(rnd_coord(32767));
    idle(6);

    phase = "R2 load";
    load_random(512, 8);
    wr(8'h80, $urandom_range(0, 65535));
    idle(6);

    phase = "R3 random gaps";
    for (int t = 0; t < 300; t++) step(1'($urandom_range(0, 3) != 0), rnd_coord(2048), 1'b0, '0, '0);
    idle(6);

    phase = "R8 back-to-back";
    for (int t = 0; t < 100; t++) fit(rnd_coord(2048));
    idle(6);

    phase = "R6 small residuals";
    wr(8'h80, 40);
    idle(6);
    for (int t = 0; t < 200; t++) fit(rnd_coord(12));
    idle(6);

    // R6: exact cut boundary, residuals from offsets only
    phase = "R6 boundary";
    for (int r = 5; r < 8; r++) for (int c = 0; c < 8; c++) wr(8'((r << 4) | c), 0);
    wr(8'h58, 6); wr(8'h68, 2); wr(8'h78, 0);
    fit(rnd_coord(32767));
    wr(8'h78, 1);
    fit(rnd_coord(32767));
    idle(6);

    phase = "R4 saturation";
    for (int c = 0; c < 8; c++) wr(8'(c), 32767);
    wr(8'h08, 0);
    for (int j = 0; j < 8; j++) x[j] = 16'h7FFF;
    fit(x);
    for (int j = 0; j < 8; j++) x[j] = 16'h8000;
    fit(x);
    idle(6);

    phase = "R5 chi2 overflow";
    wr(8'h58, 32767); wr(8'h68, 32767); wr(8'h78, 32767);
    fit(rnd_coord(32767));
    wr(8'h58, -32768);
    fit(rnd_coord(32767));
    idle(6);

    phase = "R9 unused columns";
    wr(8'h58, 3); wr(8'h68, 0); wr(8'h78, 0);
    for (int c = 9; c < 16; c++) wr(8'(16 | c), 32767);
    for (int c = 9; c < 16; c++) wr(8'(16*5 | c), 32767);
    for (int t = 0; t < 4; t++) fit(rnd_coord(4096));
    idle(6);

    report();
    $finish;
  end
endmodule